// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Port

This block is a master-mode, clock-synchronous serial port. It sends and receives 8-bit frames at the same time over one serial clock that it generates itself. A host reaches it through a small register window. The window holds a transmit holding byte, a receive holding byte, a flag register and a control register. The control register has one enable bit for the transmitter and another for the receiver.

Frames go least significant bit first. The serial clock sits high between frames. Each bit is driven when the clock falls and captured when it rises. Each clock phase lasts `HALF_DIV` system clock cycles. When a frame starts, the transmit holding byte is moved into the shifter and the transmit-empty flag goes up again. The host can then queue the next byte while the current frame is still shifting.

A frame can finish while the previous received byte is still unread. In that case the new byte is dropped and the overrun flag rises. The port then starts no further frame in either direction until the host has cleared the overrun flag with a read followed by a write of 0.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the flag register reads tx_empty=1, rx_full=0, overrun=0, and both the serial clock and the serial data output are high.
- R2: Register offsets are: 0 transmit byte (write), 1 received byte (read), 2 flags (bit0 tx_empty, bit1 rx_full, bit2 overrun), 3 control (bit0 transmit enable, bit1 receive enable). Writing offset 0 clears tx_empty.
- R3: Reading offset 1 clears rx_full.
- R4: A frame is 8 bits, least significant bit first. The serial clock idles high. Output data changes on each falling edge, input data is captured on each rising edge, and each phase lasts HALF_DIV cycles.
- R5: A frame starts when at least one enable is set, overrun is 0, and either the transmitter is disabled or tx_empty is 0. At that start the transmit byte is copied into the shifter and tx_empty returns to 1.
- R6: With both enables set, transmit and receive run in the same frame. At the end of the frame the captured byte appears at offset 1 and rx_full is set.
- R7: While the transmitter is enabled and tx_empty is 1, no frame starts and the serial clock stays high.
- R8: If a frame completes while rx_full is 1 and no read of offset 1 happens in that cycle, the new byte is discarded, the received byte is unchanged, and overrun is set.
- R9: While overrun is 1, no frame starts in either direction.
- R10: Overrun clears only when offset 2 is read while overrun is 1 and a later write to offset 2 has bit2=0. A write of 0 without that prior read leaves overrun set.
- R11: Clearing both enable bits stops a frame in progress and returns the serial clock and data output high.
- R12: If the next transmit byte is written before the current frame ends, the serial clock stays high for exactly HALF_DIV+1 cycles between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| sck | output | 1 | Serial clock, idles high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bench acts as the remote device on the serial lines and compares every frame with bytes queued by the driver. A bit-order or clock-edge fault therefore shows up as a byte mismatch. The bench checks the overrun sequence with care:
- A design that lets the second frame overwrite the unread byte returns the wrong value.
- A design that clears overrun on a bare write of 0 fails the follow-up flag read.
- A design that keeps clocking while overrun is set breaks the idle-high window.

The bench also times the idle gap between back-to-back frames, which catches an extra idle cycle. It checks that the port stays silent when the transmit byte is stale. Finally, it drops both enables mid-frame and requires the lines to return high at once.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int FRAME_BITS = 8;

    typedef enum logic [1:0] {
        A_TXB  = 2'd0,
        A_RXB  = 2'd1,
        A_FLAG = 2'd2,
        A_CTRL = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH
    } eng_state_e;

    typedef struct packed {
        logic ovr;
        logic full;
        logic empty;
    } flags_t;

    function automatic logic [7:0] pack_flags(flags_t f);
        return {5'b0, f};
    endfunction

endpackage

// File: rtl/ssp_halfdiv.sv
module ssp_halfdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int BITS     = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            keep,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic [BITS-1:0] tx_word,
    input  logic            rxd,
    output logic            sck,
    output logic            txd,
    output logic            load,
    output logic            done_rx,
    output logic [BITS-1:0] rx_word
);
    localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;

    eng_state_e      state;
    logic [IW-1:0]   bit_idx;
    logic [BITS-1:0] tx_sh, rx_sh;
    logic            fr_tx, fr_rx, sck_q, tick, last, done;

    ssp_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .run (state != ENG_IDLE),
        .tick(tick)
    );

    assign last    = (bit_idx == IW'(BITS - 1));
    assign load    = (state == ENG_IDLE) && go;
    assign done    = (state == ENG_HIGH) && tick && last && keep;
    assign done_rx = done && fr_rx;
    assign rx_word = rx_sh;
    assign sck     = sck_q;
    assign txd     = (state != ENG_IDLE && fr_tx) ? tx_sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            sck_q   <= 1'b1;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            fr_tx   <= 1'b0;
            fr_rx   <= 1'b0;
        end else if (state != ENG_IDLE && !keep) begin
            state <= ENG_IDLE;
            sck_q <= 1'b1;
        end else begin
            case (state)
                ENG_IDLE: if (go) begin
                    state   <= ENG_LOW;
                    sck_q   <= 1'b0;
                    tx_sh   <= tx_word;
                    bit_idx <= '0;
                    fr_tx   <= tx_en;
                    fr_rx   <= rx_en;
                end
                ENG_LOW: if (tick) begin
                    state <= ENG_HIGH;
                    sck_q <= 1'b1;
                    rx_sh <= {rxd, rx_sh[BITS-1:1]};
                end
                ENG_HIGH: if (tick) begin
                    if (last) begin
                        state <= ENG_IDLE;
                    end else begin
                        state   <= ENG_LOW;
                        sck_q   <= 1'b0;
                        tx_sh   <= {1'b0, tx_sh[BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R4: clock is high whenever no frame is running
    p_idle_clock_high_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_IDLE) |-> sck_q);

    // R4: output data only moves at a falling edge
    p_data_steady_high_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_HIGH && !tick && keep) |=> $stable(txd));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       sck,
    output logic       txd,
    input  logic       rxd
);
    logic [7:0] tdr, rdr, rx_word;
    flags_t     f;
    logic       te, re, armed;
    logic       wr_tdr, rd_rdr, rd_st, wr_st, wr_ctl;
    logic       go, load, done_rx;

    assign wr_tdr = wr_en && (addr == A_TXB);
    assign rd_rdr = rd_en && (addr == A_RXB);
    assign rd_st  = rd_en && (addr == A_FLAG);
    assign wr_st  = wr_en && (addr == A_FLAG);
    assign wr_ctl = wr_en && (addr == A_CTRL);

    assign go = (te || re) && !f.ovr && (!te || !f.empty);

    ssp_engine #(.HALF_DIV(HALF_DIV), .BITS(FRAME_BITS)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .keep   (te || re),
        .tx_en  (te),
        .rx_en  (re),
        .tx_word(tdr),
        .rxd    (rxd),
        .sck    (sck),
        .txd    (txd),
        .load   (load),
        .done_rx(done_rx),
        .rx_word(rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tdr     <= '0;
            rdr     <= '0;
            f.empty <= 1'b1;
            f.full  <= 1'b0;
            f.ovr   <= 1'b0;
            te      <= 1'b0;
            re      <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (wr_ctl) begin
                te <= wdata[0];
                re <= wdata[1];
            end
            if (wr_tdr) begin
                tdr     <= wdata;
                f.empty <= 1'b0;
            end else if (load && te) begin
                f.empty <= 1'b1;
            end
            if (done_rx) begin
                if (f.full && !rd_rdr) begin
                    f.ovr <= 1'b1;
                end else begin
                    rdr    <= rx_word;
                    f.full <= 1'b1;
                end
            end else if (rd_rdr) begin
                f.full <= 1'b0;
            end
            if (rd_st && f.ovr) armed <= 1'b1;
            if (wr_st && !wdata[2] && armed) begin
                f.ovr <= 1'b0;
                armed <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_TXB:   rdata = tdr;
            A_RXB:   rdata = rdr;
            A_FLAG:  rdata = pack_flags(f);
            default: rdata = {6'b0, re, te};
        endcase
    end

    p_tdr_write_clears_r2: assert property (@(posedge clk) disable iff (rst)
        wr_tdr |=> !f.empty);

    p_rdr_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_rdr && !done_rx) |=> !f.full);

    p_load_refills_r5: assert property (@(posedge clk) disable iff (rst)
        (load && te && !wr_tdr) |=> f.empty);

    p_no_stale_load_r7: assert property (@(posedge clk) disable iff (rst)
        (load && te) |-> !f.empty);

    p_overrun_keeps_rdr_r8: assert property (@(posedge clk) disable iff (rst)
        (done_rx && f.full && !rd_rdr) |=> ($stable(rdr) && f.ovr));

    p_ovr_blocks_start_r9: assert property (@(posedge clk) disable iff (rst)
        f.ovr |-> !load);

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (f.ovr && !wr_st) |=> f.ovr);

endmodule

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
    localparam int HD = 2;
    localparam logic [1:0] OFS_TX = 2'd0, OFS_RX = 2'd1, OFS_FL = 2'd2, OFS_CT = 2'd3;

    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic       sck, txd, rxd = 1'b1;

    int n_tests = 0, n_fail = 0;

    logic [7:0] tx_exp_q[$];
    logic [7:0] rx_src_q[$];
    logic [7:0] rx_exp_q[$];
    bit         mon_tx = 1'b0;
    int         fall_n = 0, rise_n = 0, high_run = 0, gap_run = 0, frames_done = 0;
    logic [7:0] cur_out = 8'h00, cap = 8'h00;

    sync_serial_port #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck(sck), .txd(txd), .rxd(rxd)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // driver: queue the expected transmit byte and the byte the remote side sends
    task automatic send(input logic [7:0] tx, input logic [7:0] rx);
        tx_exp_q.push_back(tx);
        rx_src_q.push_back(rx);
        rx_exp_q.push_back(rx);
        wr(OFS_TX, tx);
    endtask

    task automatic wait_full(input string req);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < 400 && !s[1]; k++) rd(OFS_FL, s);
        if (!s[1]) chk(req, "rx_full never set", 0, 1);
    endtask

    task automatic take_rx(input string req);
        logic [7:0] d, e;
        rd(OFS_RX, d);
        e = (rx_exp_q.size() > 0) ? rx_exp_q.pop_front() : 8'hxx;
        chk(req, "received byte", d, e);
    endtask

    task automatic hold_high(input int n, input string req);
        int bad;
        bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (sck !== 1'b1 || txd !== 1'b1) bad++;
        end
        chk(req, "lines idle high (bad cycles)", bad, 0);
    endtask

    always @(negedge clk) high_run = (sck === 1'b1) ? high_run + 1 : 0;

    // remote device: drive on falling edge
    initial begin
        @(negedge rst);
        forever begin
            @(negedge sck);
            if (fall_n == 0) begin
                cur_out = (rx_src_q.size() > 0) ? rx_src_q.pop_front() : 8'h00;
                gap_run = high_run;
            end
            rxd = cur_out[fall_n];
            fall_n = (fall_n + 1) % 8;
        end
    end

    // monitor: capture on rising edge, compare with scoreboard
    initial begin
        @(negedge rst);
        forever begin
            @(posedge sck);
            cap[rise_n] = txd;
            rise_n++;
            if (rise_n == 8) begin
                rise_n = 0;
                frames_done++;
                if (mon_tx) begin
                    if (tx_exp_q.size() > 0) chk("R4 R6", "sent byte", cap, tx_exp_q.pop_front());
                    else chk("R7", "unexpected frame", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] s;
        logic [7:0] pat_tx[4];
        logic [7:0] pat_rx[4];
        pat_tx = '{8'h00, 8'hFF, 8'h81, 8'h7E};
        pat_rx = '{8'h96, 8'h69, 8'h01, 8'h80};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1", "sck after reset", sck, 1);
        chk("R1", "txd after reset", txd, 1);
        rd(OFS_FL, s);
        chk("R1", "flags after reset", s, 8'h01);

        // R2: write with both disabled clears tx_empty, nothing moves
        send(8'h3C, 8'hA5);
        rd(OFS_FL, s);
        chk("R2", "tx_empty cleared by write", s, 8'h00);
        hold_high(40, "R5");

        // R5 R6: enable both, shifter loads
        mon_tx = 1'b1;
        wr(OFS_CT, 8'h03);
        repeat (3) @(negedge clk);
        rd(OFS_FL, s);
        chk("R5", "tx_empty set at frame start", s[0], 1);
        send(8'hC3, 8'h5A);
        wait_full("R6");
        take_rx("R6");
        rd(OFS_FL, s);
        chk("R3", "rx_full cleared by read", s[1], 0);
        wait_full("R6");
        chk("R12", "high run between back-to-back frames", gap_run, HD + 1);
        take_rx("R6");
        hold_high(60, "R7");

        for (int i = 0; i < 4; i++) begin
            send(pat_tx[i], pat_rx[i]);
            wait_full("R6");
            take_rx("R6");
        end
        repeat (40) @(negedge clk);
        chk("R6", "all queued bytes sent", tx_exp_q.size(), 0);

        // R8 R9 R10: receive-only overrun
        mon_tx = 1'b0;
        wr(OFS_CT, 8'h02);
        rx_src_q.push_back(8'h11);
        rx_src_q.push_back(8'h22);
        repeat (120) @(negedge clk);
        hold_high(30, "R9");
        wr(OFS_FL, 8'h00);
        rd(OFS_FL, s);
        chk("R10", "overrun kept after bare write of 0", s, 8'h07);
        rd(OFS_RX, s);
        chk("R8", "first byte kept, second dropped", s, 8'h11);
        rx_src_q.push_back(8'h33);
        wr(OFS_FL, 8'h00);
        rd(OFS_FL, s);
        chk("R10", "overrun cleared after read then write", s, 8'h01);
        rx_exp_q.delete();
        rx_exp_q.push_back(8'h33);
        wait_full("R9");
        take_rx("R9");
        wr(OFS_CT, 8'h00);
        repeat (4) @(negedge clk);
        fall_n = 0; rise_n = 0;
        rx_src_q.delete();

        // R11: abort mid-frame
        wr(OFS_CT, 8'h03);
        wr(OFS_TX, 8'hF0);
        repeat (5) @(negedge clk);
        chk("R11", "frame running before abort", sck === 1'b0 || txd === 1'b0 ? 1 : (high_run < HD + 1 ? 1 : 0), 1);
        wr(OFS_CT, 8'h00);
        hold_high(40, "R11");
        rd(OFS_FL, s);
        chk("R5", "tx_empty after abort of loaded frame", s[0], 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule